// File: doc/BRIEF.md
# Program/Erase Completion Status Unit

This block produces what a host sees on the data bus and on the ready/busy line while a nonvolatile array runs an internally timed byte program or a full erase. A one-cycle start pulse, for a program or for an erase, begins the operation. A program start also captures the target address and the most significant bit of the byte being written. The duration is a parameter in clock cycles. The block counts it down on its own and needs no further input from the host.

While the operation runs, the host can find out when it ends in three ways. It can read the target address and watch the top bit come back inverted. It can read any address and watch bit 6 flip on every read strobe. It can watch the open-drain ready/busy pull-down. When the operation ends, every read returns the true stored byte again. Driving the active-low reset pin low aborts the operation, releases the ready/busy line and floats the bus. The array itself and the command decoding sit outside the block: the stored byte for the current read address arrives on `array_data`.

Top module: `prog_status_unit`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0 and `rb_pull_low` is 0. A program or erase in progress is abandoned, and after release the block is idle, with true data on reads and the toggle state at 0.
- R2: `dq_oe` is 1 only when `rst_n` is high and `ce_n` and `oe_n` are both low. `dq_out` is all zeros whenever `dq_oe` is 0.
- R3: A start accepted while idle sets `rb_pull_low` from the next cycle. It stays set for exactly PROG_CYCLES cycles for a program or ERASE_CYCLES cycles for an erase. When `start_prog` and `start_erase` arrive together, the program wins.
- R4: A start pulse that arrives while busy is ignored. It does not extend the operation, change its kind, or replace the captured address or top bit.
- R5: During a program, a read whose `rd_addr` equals the captured address returns, on bit DW-1 (bit 7 at the default DW=8), the complement of the captured top bit.
- R6: While busy, bit DW-2 (bit 6 at DW=8) carries the toggle state. The state flips once for each completed read strobe, which is an access cycle followed by a non-access cycle at a clock edge. It holds otherwise and reset clears it to 0.
- R7: While busy, every other bit equals `array_data`. Bit DW-1 also equals `array_data` during an erase, and during a program at any address other than the captured one.
- R8: While idle, an enabled read returns `array_data` on all bits, and read strobes do not change the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and abort pin (asynchronous) |
| start_prog | input | 1 | One-cycle pulse that starts a byte program |
| start_erase | input | 1 | One-cycle pulse that starts a full erase |
| load_addr | input | AW | Address of the byte being programmed |
| load_msb | input | 1 | Top bit of the byte being programmed |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| rd_addr | input | AW | Current read address |
| array_data | input | DW | Stored byte at `rd_addr` |
| dq_out | output | DW | Read data toward the bus |
| dq_oe | output | 1 | Bus driver enable (0 = high impedance) |
| rb_pull_low | output | 1 | 1 = pull the open-drain ready/busy line low |

## Verification
The assertions check four things on every clock cycle. The bus enable follows the two strobes. The busy window opens after an accepted start and closes after exactly the parameterised length, measured by a checker counter. The operation kind holds steady while busy. The inverted polling bit appears at the captured address, the toggle bit stays frozen while idle, and idle reads return the array byte.

Some behaviour only the bench scenarios can show. These are the abort by reset in the middle of an operation, a start ignored during a busy window, program priority on simultaneous starts, and the exact toggle sequence over a train of read strobes. Those scenarios run beside long random stretches, and a bench model predicts every output in every cycle.

// File: rtl/pst_pkg.sv
package pst_pkg;

   typedef enum logic [0:0] {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pst_op_timer.sv
module pst_op_timer
   import pst_pkg::*;
#(
   parameter int unsigned PROG_CYCLES  = 1250,
   parameter int unsigned ERASE_CYCLES = 1250000000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_prog,
   input  logic     start_erase,
   output logic     busy,
   output op_kind_e kind,
   output logic     accept_prog
);

   localparam int unsigned MAXC = max_u(PROG_CYCLES, ERASE_CYCLES);
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
   localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 1");
   end
   if (ERASE_CYCLES < 1) begin : g_bad_erase
      $error("ERASE_CYCLES must be at least 1");
   end

   logic [CW-1:0] remain;
   logic          accept;

   assign accept      = !busy && (start_prog || start_erase);
   assign accept_prog = !busy && start_prog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
         kind   <= OP_PROG;
      end else if (!busy) begin
         if (start_prog) begin
            busy   <= 1'b1;
            remain <= PROG_LOAD;
            kind   <= OP_PROG;
         end else if (start_erase) begin
            busy   <= 1'b1;
            remain <= ERASE_LOAD;
            kind   <= OP_ERASE;
         end
      end else if (remain == '0) begin
         busy <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end

   // Independent window counter used only by the duration check
   logic [CW:0] win_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     win_len <= '0;
      else if (accept)                win_len <= 1;
      else if (busy && remain != '0)  win_len <= win_len + 1'b1;
   end

   assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (win_len == ((kind == OP_PROG) ? (CW+1)'(PROG_CYCLES)
                                                     : (CW+1)'(ERASE_CYCLES))));

   assert_kind_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(kind));

endmodule

// File: rtl/pst_toggle_bit.sv
module pst_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   input  logic busy,
   output logic tog
);

   logic access_q;
   logic strobe_done;

   assign strobe_done = access_q && !access;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         access_q <= 1'b0;
         tog      <= 1'b0;
      end else begin
         access_q <= access;
         if (strobe_done && busy) tog <= ~tog;
      end
   end

   assert_toggle_frozen_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));

   assert_toggle_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_done |=> $stable(tog));

endmodule

// File: rtl/pst_read_path.sv
module pst_read_path
   import pst_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 20
) (
   input  logic          rst_n,
   input  logic          access,
   input  logic          busy,
   input  op_kind_e      kind,
   input  logic [AW-1:0] rd_addr,
   input  logic [AW-1:0] last_addr,
   input  logic          last_msb,
   input  logic [DW-1:0] array_data,
   input  logic          tog,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe
);

   localparam int unsigned POLL_BIT = DW - 1;
   localparam int unsigned TOG_BIT  = DW - 2;

   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   logic          poll_hit;
   logic [DW-1:0] status_word;

   assign dq_oe    = rst_n && access;
   assign poll_hit = busy && (kind == OP_PROG) && (rd_addr == last_addr);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign status_word[b] = poll_hit ? ~last_msb : array_data[b];
      end else if (b == TOG_BIT) begin : g_tog
         assign status_word[b] = busy ? tog : array_data[b];
      end else begin : g_plain
         assign status_word[b] = array_data[b];
      end
   end

   assign dq_out = dq_oe ? status_word : '0;

endmodule

// File: rtl/prog_status_unit.sv
module prog_status_unit
   import pst_pkg::*;
#(
   parameter int unsigned DW           = 8,
   parameter int unsigned AW           = 20,
   parameter int unsigned PROG_CYCLES  = 1250,
   parameter int unsigned ERASE_CYCLES = 1250000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_prog,
   input  logic          start_erase,
   input  logic [AW-1:0] load_addr,
   input  logic          load_msb,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   output logic          rb_pull_low
);

   localparam int unsigned POLL_BIT = DW - 1;

   logic          busy;
   logic          accept_prog;
   op_kind_e      kind;
   logic          tog;
   logic          access;
   logic [AW-1:0] last_addr;
   logic          last_msb;

   assign access      = !ce_n && !oe_n;
   assign rb_pull_low = busy;

   pst_op_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (start_prog),
      .start_erase(start_erase),
      .busy       (busy),
      .kind       (kind),
      .accept_prog(accept_prog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         last_msb  <= 1'b0;
      end else if (accept_prog) begin
         last_addr <= load_addr;
         last_msb  <= load_msb;
      end
   end

   pst_toggle_bit u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .access(access),
      .busy  (busy),
      .tog   (tog)
   );

   pst_read_path #(
      .DW(DW),
      .AW(AW)
   ) u_read (
      .rst_n     (rst_n),
      .access    (access),
      .busy      (busy),
      .kind      (kind),
      .rd_addr   (rd_addr),
      .last_addr (last_addr),
      .last_msb  (last_msb),
      .array_data(array_data),
      .tog       (tog),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe)
   );

   assert_oe_needs_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!ce_n && !oe_n));

   assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));

   assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rb_pull_low) |-> $past(start_prog || start_erase));

   assert_capture_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(last_addr) && $stable(last_msb)));

   assert_poll_inverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind == OP_PROG && rd_addr == last_addr && dq_oe)
         |-> (dq_out[POLL_BIT] != last_msb));

   assert_idle_true_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && dq_oe) |-> (dq_out == array_data));

endmodule

// File: tb/tb_prog_status_unit.sv
module tb_prog_status_unit;

   localparam int unsigned DW = 8;
   localparam int unsigned AW = 8;
   localparam int unsigned PC = 20;
   localparam int unsigned EC = 60;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_prog, start_erase;
   logic [AW-1:0] load_addr;
   logic          load_msb;
   logic          ce_n, oe_n;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] array_data;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic          rb_pull_low;

   always #4 clk = ~clk;

   prog_status_unit #(.DW(DW), .AW(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .load_addr(load_addr), .load_msb(load_msb), .ce_n(ce_n), .oe_n(oe_n),
      .rd_addr(rd_addr), .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe),
      .rb_pull_low(rb_pull_low)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // bench model of the requirements
   bit            m_busy, m_erase, m_msb, m_tog, m_acc_q;
   int            m_left;
   logic [AW-1:0] m_addr;

   function automatic logic [DW:0] exp_bus();
      logic [DW-1:0] d;
      bit acc;
      acc = !ce_n && !oe_n && rst_n;
      if (!acc) return '0;
      d = array_data;
      if (m_busy) begin
         d[DW-2] = m_tog;
         if (!m_erase && rd_addr == m_addr) d[DW-1] = ~m_msb;
      end
      return {1'b1, d};
   endfunction

   function automatic string tag_now();
      if (!rst_n) return "R1";
      if (ce_n || oe_n) return "R2";
      if (m_busy && !m_erase && rd_addr == m_addr) return "R5";
      if (m_busy) return "R6/R7";
      return "R8";
   endfunction

   task automatic check_now(string extra);
      logic [DW:0] e;
      bit erb;
      e   = exp_bus();
      erb = rst_n && m_busy;
      checks++;
      if ({dq_oe, dq_out} !== e || rb_pull_low !== erb) begin
         errors++;
         $display("FAIL %s %s: oe/dq/rb = %b/%h/%b expected %b/%h/%b",
                  tag_now(), extra, dq_oe, dq_out, rb_pull_low, e[DW], e[DW-1:0], erb);
      end
   endtask

   task automatic model_edge();
      bit acc;
      acc = !ce_n && !oe_n;
      if (!rst_n) begin
         m_busy = 0; m_erase = 0; m_tog = 0; m_acc_q = 0; m_left = 0;
         m_addr = '0; m_msb = 0;
         return;
      end
      if (m_acc_q && !acc && m_busy) m_tog = ~m_tog;
      m_acc_q = acc;
      if (m_busy) begin
         m_left--;
         if (m_left == 0) m_busy = 0;
      end else if (start_prog) begin
         m_busy = 1; m_erase = 0; m_left = PC; m_addr = load_addr; m_msb = load_msb;
      end else if (start_erase) begin
         m_busy = 1; m_erase = 1; m_left = EC;
      end
   endtask

   task automatic tick(string extra);
      #1;
      check_now(extra);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      start_prog  = 0;
      start_erase = 0;
   endtask

   task automatic rand_read(int pct_access);
      bit acc;
      acc        = ($urandom_range(99) < pct_access);
      ce_n       = acc ? 1'b0 : 1'($urandom_range(1));
      oe_n       = acc ? 1'b0 : 1'b1;
      array_data = DW'($urandom);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      rst_n = 0; start_prog = 0; start_erase = 0; load_addr = '0; load_msb = 0;
      ce_n = 1; oe_n = 1; rd_addr = '0; array_data = '0;
      m_busy = 0; m_erase = 0; m_tog = 0; m_acc_q = 0; m_left = 0; m_addr = '0; m_msb = 0;
      @(negedge clk);
      // R1: reset state with strobes active
      ce_n = 0; oe_n = 0; array_data = 8'hC3;
      repeat (3) tick("reset state R1");
      rst_n = 1;

      // R2, R8: idle reads
      for (int i = 0; i < 30; i++) begin
         rd_addr = AW'($urandom); rand_read(60); tick("idle read R8");
      end

      // R3, R5, R6, R7: program, poll at target, toggle train
      begin
         int rb_len;
         load_addr = 8'h3C; load_msb = 1; start_prog = 1;
         ce_n = 1; oe_n = 1;
         tick("program start R3");
         rb_len = 0;
         for (int i = 0; i < PC + 4; i++) begin
            if (rb_pull_low) rb_len++;
            rd_addr    = (i % 3 == 0) ? 8'h3C : AW'($urandom);
            ce_n       = 0;
            oe_n       = (i % 2 == 0) ? 1'b0 : 1'b1;
            array_data = DW'($urandom);
            tick("program busy R5 R6");
         end
         checks++;
         if (rb_len != PC) begin
            errors++;
            $display("FAIL R3 program busy length: %0d expected %0d", rb_len, PC);
         end
      end

      // R5 with top bit 0, directed poll read
      load_addr = 8'h01; load_msb = 0; start_prog = 1; ce_n = 1; oe_n = 1;
      tick("program start R3");
      rd_addr = 8'h01; ce_n = 0; oe_n = 0; array_data = 8'h00;
      tick("poll bit R5");
      checks++;
      if (dq_out[7] !== 1'b1) begin
         errors++;
         $display("FAIL R5 poll bit: %b expected 1", dq_out[7]);
      end

      // R4: starts during busy ignored (address unchanged, no erase)
      load_addr = 8'h77; load_msb = 1; start_prog = 1; start_erase = 1;
      tick("start while busy R4");
      for (int i = 0; i < PC + 2; i++) begin
         rd_addr = (i % 2 == 0) ? 8'h01 : 8'h77;
         ce_n = 0; oe_n = 1'(i % 2); array_data = DW'($urandom);
         tick("after ignored start R4");
      end

      // R3 priority: both starts together -> program length
      begin
         int rb_len;
         load_addr = 8'h10; load_msb = 1; start_prog = 1; start_erase = 1; ce_n = 1; oe_n = 1;
         tick("priority start R3");
         rb_len = 0;
         for (int i = 0; i < EC + 4; i++) begin
            if (rb_pull_low) rb_len++;
            tick("priority run R3");
         end
         checks++;
         if (rb_len != PC) begin
            errors++;
            $display("FAIL R3 priority length: %0d expected %0d", rb_len, PC);
         end
      end

      // R7: erase, top bit follows array even at last program address
      start_erase = 1; tick("erase start R3");
      for (int i = 0; i < EC + 3; i++) begin
         rd_addr = 8'h10; ce_n = 0; oe_n = 1'(i % 2); array_data = DW'($urandom);
         tick("erase busy R7");
      end

      // R1: abort in the middle of an erase
      start_erase = 1; tick("erase start R3");
      repeat (10) begin rand_read(50); tick("erase before abort R1"); end
      rst_n = 0; ce_n = 0; oe_n = 0;
      repeat (2) tick("abort R1");
      rst_n = 1;
      repeat (5) begin rand_read(70); tick("after abort R1"); end

      // random stretch
      for (int i = 0; i < 4000; i++) begin
         rand_read(50);
         rd_addr = ($urandom_range(3) == 0) ? m_addr : AW'($urandom);
         if ($urandom_range(40) == 0) begin
            start_prog = 1; load_addr = AW'($urandom); load_msb = 1'($urandom);
         end
         if ($urandom_range(150) == 0) start_erase = 1;
         if ($urandom_range(700) == 0) rst_n = 0;
         else rst_n = 1;
         tick("random mix");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule